// File: doc/BRIEF.md
# Compare-Clear Free-Running Timer

This block is a 16-bit up-counter that runs freely. Its count source is either a prescaled copy of the bus clock or the synchronized rising edges of an external pin. A 16-bit compare register is checked against the counter on every count step. In clear-on-match mode, a match sends the counter back to zero, so the compare value sets the period. A wrap from the top of the range raises an overflow flag, and a match raises a match flag. Each flag has its own enable, and the two enabled flags are combined into a single interrupt request.

Software reaches three word-wide registers over a plain synchronous register bus with two byte lanes. Word 0 holds the counter, word 1 holds the compare value and word 2 holds the control word. Word 3 reads as zero. Reads are combinational from the address.

Control word layout, by bit:

| Bit | Field |
|---|---|
| 2:0 | clock select |
| 3 | software clear |
| 4 | clear-on-match mode |
| 5 | halt |
| 6 | overflow interrupt enable |
| 7 | overflow flag |
| 8 | match interrupt enable |
| 9 | match flag |
| 15 | external clock enable |

The other bits are reserved and read as 0.

Top module: `cmpclr_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the control word reads 0x0000, the compare register reads 0xFFFF, and `irq` is 0.
- R2: The compare register (word 1) is written only when both byte enables are 1. A write with any other byte enable pattern leaves it unchanged.
- R3: The counter (word 0) is written byte-wise: `bus_be[0]` selects bits 7:0 and `bus_be[1]` selects bits 15:8. A bus write takes priority over a count step in the same cycle. Otherwise the counter rises by one on each count tick while halt (bit 5) is 0.
- R4: When bit 15 is 0, the count tick is internal, with a period of 2^(sel+1) bus clocks, where sel is bits 2:0. The tick fires in the cycle n after reset release (n counted from 0) for which n mod 2^(sel+1) equals 2^(sel+1)-1.
- R5: When bit 15 is 1, the count tick comes from `ext_clk_pin`. A low-to-high change first sampled high at clock edge k advances the counter at edge k+2.
- R6: A count tick taken while the counter equals the compare value sets the match flag (bit 9). With mode (bit 4) at 1 that step loads 0x0000; with mode at 0 it increments as usual.
- R7: A count tick at 0xFFFF that is not a mode-1 match wraps the counter to 0x0000 and sets the overflow flag (bit 7).
- R8: With halt at 1 and no counter write or software clear, the counter holds its value.
- R9: Writing 1 to bit 3 of the control word (low lane enabled) makes the counter read 0x0000 after that clock edge. Bit 3 always reads 0.
- R10: A flag is cleared by a control write carrying 0 in its bit on the enabled lane. A 1 leaves it as it is. A set event in the same cycle as a clear write leaves the flag at 1.
- R11: `irq` is 1 exactly when (bit 7 and bit 6) or (bit 9 and bit 8) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bus_sel | input | 1 | register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | word index: 0 counter, 1 compare, 2 control |
| bus_be | input | 2 | byte lane enables for writes |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data of the addressed word |
| ext_clk_pin | input | 1 | external count source, asynchronous |
| irq | output | 1 | combined interrupt request |

## Verification
The assertions assume that bus signals are stable at the sampling edge and that a write to word 0 or a software clear is the only event that overrides a count step. Under that assumption the halt, reload and wrap properties apply only when no such write is present in the cycle. The stimulus changes every input at the falling edge. It keeps compare values small and clock selects low, so that matches, reloads and wraps occur often. It drives the external pin with slow random toggles that the two-stage synchronizer can follow.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        A_COUNT = 2'd0,
        A_CMP   = 2'd1,
        A_CTRL  = 2'd2,
        A_NONE  = 2'd3
    } addr_e;

    typedef struct packed {
        logic       ext_en;
        logic       mf;
        logic       m_ie;
        logic       ovf;
        logic       ovf_ie;
        logic       halt;
        logic       mode;
        logic [2:0] csel;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] count;
        logic [DW-1:0] cmp;
        ctrl_t         ctrl;
    } tstate_t;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 1 << SEL_W;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] keep_mask;

    always_comb begin
        pre_d     = pre_q + 1'b1;
        keep_mask = ~({PRE_W{1'b1}} << (sel + 1));
        tick      = &(pre_q | ~keep_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R4: the fastest setting ticks on every second cycle, never twice in a row
    AST_FAST_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && $past(sel) == '0 && tick) |=> !tick); // R4
endmodule

// File: rtl/cct_ext_sync.sv
module cct_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic tick
);
    logic [STAGES:0] sync_d, sync_q;

    generate
        if (STAGES < 1) begin : g_bad
            initial $error("cct_ext_sync needs at least one stage");
        end
    endgenerate

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], pin};
        tick   = sync_q[STAGES-1] & ~sync_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // R5: an edge produces one tick, never two on adjacent cycles
    AST_ONE_TICK_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/cmpclr_timer.sv
module cmpclr_timer
    import cct_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [1:0]    bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_clk_pin,
    output logic          irq
);
    localparam logic [DW-1:0] TOP = {DW{1'b1}};

    tstate_t s_d, s_q;
    logic    int_tick, ext_tick, tick, adv, hit;
    logic    set_m, set_o, wr, wr_cnt, wr_cmp, wr_ctrl, sclr_wr;
    logic    unused_wbits;

    assign unused_wbits = ^bus_wdata[14:10];

    cct_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(s_q.ctrl.csel), .tick(int_tick)
    );

    cct_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .tick(ext_tick)
    );

    always_comb begin
        s_d     = s_q;
        wr      = bus_sel && bus_wr;
        wr_cnt  = wr && (bus_addr == A_COUNT) && (|bus_be);
        wr_cmp  = wr && (bus_addr == A_CMP) && (&bus_be);
        wr_ctrl = wr && (bus_addr == A_CTRL);
        sclr_wr = wr_ctrl && bus_be[0] && bus_wdata[3];

        tick  = s_q.ctrl.ext_en ? ext_tick : int_tick;
        adv   = tick && !s_q.ctrl.halt;
        hit   = (s_q.count == s_q.cmp);
        set_m = adv && hit;
        set_o = adv && (s_q.count == TOP) && !(s_q.ctrl.mode && hit);

        if (adv) begin
            if (s_q.ctrl.mode && hit) s_d.count = '0;
            else                      s_d.count = s_q.count + 1'b1;
        end

        if (wr_cnt) begin
            if (bus_be[0]) s_d.count[7:0]  = bus_wdata[7:0];
            if (bus_be[1]) s_d.count[15:8] = bus_wdata[15:8];
        end
        if (wr_cmp) s_d.cmp = bus_wdata;

        if (wr_ctrl && bus_be[0]) begin
            s_d.ctrl.csel   = bus_wdata[2:0];
            s_d.ctrl.mode   = bus_wdata[4];
            s_d.ctrl.halt   = bus_wdata[5];
            s_d.ctrl.ovf_ie = bus_wdata[6];
            if (!bus_wdata[7]) s_d.ctrl.ovf = 1'b0;
            if (bus_wdata[3])  s_d.count    = '0;
        end
        if (wr_ctrl && bus_be[1]) begin
            s_d.ctrl.m_ie   = bus_wdata[8];
            s_d.ctrl.ext_en = bus_wdata[15];
            if (!bus_wdata[9]) s_d.ctrl.mf = 1'b0;
        end

        if (set_m) s_d.ctrl.mf  = 1'b1;
        if (set_o) s_d.ctrl.ovf = 1'b1;

        unique case (bus_addr)
            A_COUNT: bus_rdata = s_q.count;
            A_CMP:   bus_rdata = s_q.cmp;
            A_CTRL:  bus_rdata = {s_q.ctrl.ext_en, 5'b0, s_q.ctrl.mf, s_q.ctrl.m_ie,
                                  s_q.ctrl.ovf, s_q.ctrl.ovf_ie, s_q.ctrl.halt,
                                  s_q.ctrl.mode, 1'b0, s_q.ctrl.csel};
            default: bus_rdata = '0;
        endcase

        irq = (s_q.ctrl.ovf && s_q.ctrl.ovf_ie) || (s_q.ctrl.mf && s_q.ctrl.m_ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count <= '0;
            s_q.cmp   <= TOP;
            s_q.ctrl  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.halt && !wr_cnt && !sclr_wr) |=> $stable(s_q.count)); // R8
    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s_q.ctrl.mode && hit && !wr_cnt && !sclr_wr) |=> (s_q.count == '0)); // R6
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hit) |=> s_q.ctrl.mf); // R10
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s_q.count == TOP && !(s_q.ctrl.mode && hit)) |=> s_q.ctrl.ovf); // R7
    AST_CMP_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_CMP && !(&bus_be)) |=> $stable(s_q.cmp)); // R2
    AST_SCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sclr_wr |=> (s_q.count == '0)); // R9
endmodule

// File: tb/cmpclr_timer_bench.sv
module cmpclr_timer_bench;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0, ext_clk_pin = 0;
    logic [1:0]  bus_addr = 0, bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        irq;

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string ph = "R1";

    // reference state, built from the requirements
    logic [15:0] m_cnt, m_cmp;
    logic [2:0]  m_sel;
    logic        m_mode, m_halt, m_oie, m_ovf, m_mie, m_mf, m_ext;
    logic        m_s1, m_s2, m_s3;
    int          m_n;

    always #5 clk = ~clk;

    cmpclr_timer u_cmpclr_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_clk_pin(ext_clk_pin), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 16'hFFFF; m_sel = 0; m_mode = 0; m_halt = 0;
            m_oie = 0; m_ovf = 0; m_mie = 0; m_mf = 0; m_ext = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_n = 0;
        end else begin
            automatic int  per  = 2 << m_sel;
            automatic bit  ti   = (m_n % per) == per - 1;          // R4
            automatic bit  te   = m_s2 && !m_s3;                   // R5
            automatic bit  adv  = (m_ext ? te : ti) && !m_halt;    // R8
            automatic bit  hit  = m_cnt == m_cmp;
            automatic bit  sm   = adv && hit;                      // R6
            automatic bit  so   = adv && m_cnt == 16'hFFFF && !(m_mode && hit); // R7
            automatic bit  w    = bus_sel && bus_wr;
            automatic logic [15:0] nc = m_cnt;
            if (adv) nc = (m_mode && hit) ? 16'h0 : m_cnt + 1;
            if (w && bus_addr == 0) begin                          // R3
                if (bus_be[0]) nc[7:0]  = bus_wdata[7:0];
                if (bus_be[1]) nc[15:8] = bus_wdata[15:8];
            end
            if (w && bus_addr == 1 && bus_be == 2'b11) m_cmp = bus_wdata; // R2
            if (w && bus_addr == 2 && bus_be[0]) begin
                m_sel = bus_wdata[2:0]; m_mode = bus_wdata[4];
                m_halt = bus_wdata[5]; m_oie = bus_wdata[6];
                if (!bus_wdata[7]) m_ovf = 0;                     // R10
                if (bus_wdata[3]) nc = 0;                          // R9
            end
            if (w && bus_addr == 2 && bus_be[1]) begin
                m_mie = bus_wdata[8]; m_ext = bus_wdata[15];
                if (!bus_wdata[9]) m_mf = 0;
            end
            if (sm) m_mf = 1;
            if (so) m_ovf = 1;
            m_cnt = nc;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_pin;
            m_n++;
        end
    end

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_cmp;
            2'd2: return {m_ext, 5'b0, m_mf, m_mie, m_ovf, m_oie, m_halt, m_mode, 1'b0, m_sel};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_ovf && m_oie) || (m_mf && m_mie);              // R11
    endfunction

    task automatic compare();
        automatic logic [15:0] e = exp_read(bus_addr);
        automatic string t = bus_addr == 0 ? "R3" : bus_addr == 1 ? "R2" : "R6";
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s/%s word%0d rdata=%h expected=%h", ph, t, bus_addr, bus_rdata, e);
        end
        n_chk++;
        if (irq !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s/R11 irq=%b expected=%b", ph, irq, exp_irq());
        end
    endtask

    task automatic op(input logic w, input logic [1:0] a, input logic [1:0] b,
                      input logic [15:0] d);
        @(negedge clk);
        compare();
        bus_sel = w; bus_wr = w; bus_addr = a; bus_be = b; bus_wdata = d;
    endtask

    task automatic idle(input logic [1:0] a, input int n);
        for (int i = 0; i < n; i++) op(0, a, 2'b00, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values of every word
        ph = "R1";
        idle(0, 2); idle(1, 1); idle(2, 1); idle(3, 1);
        // R2: partial writes to compare are ignored, full word lands
        ph = "R2";
        op(1, 1, 2'b01, 16'h0005); idle(1, 1);
        op(1, 1, 2'b10, 16'h0005); idle(1, 1);
        op(1, 1, 2'b11, 16'h0005); idle(1, 2);
        // R9 then R6: software clear, clear-on-match at fastest rate
        ph = "R9";
        op(1, 2, 2'b01, 16'h0018); idle(0, 1); idle(2, 1);
        ph = "R6";
        idle(0, 30); idle(2, 2);
        // R10: clear writes racing match events (cmp=1, period 4 cycles)
        ph = "R10";
        op(1, 1, 2'b11, 16'h0001);
        for (int i = 0; i < 12; i++) op(1, 2, 2'b10, 16'h0100);
        idle(2, 3);
        op(1, 2, 2'b10, 16'h0300); idle(2, 4);
        // R7 with R11: wrap in free-run mode, overflow enable
        ph = "R7";
        op(1, 2, 2'b11, 16'h0040);
        op(1, 0, 2'b11, 16'hFFFA); idle(0, 16); idle(2, 2);
        ph = "R11";
        op(1, 2, 2'b01, 16'h00C0); idle(2, 3);
        op(1, 2, 2'b01, 16'h0000); idle(2, 3);
        // R8: halt freezes the counter
        ph = "R8";
        op(1, 2, 2'b01, 16'h0020); idle(0, 12);
        op(1, 0, 2'b10, 16'h3300); idle(0, 4);
        // R3: byte-lane counter writes while running
        ph = "R3";
        op(1, 2, 2'b01, 16'h0001); op(1, 0, 2'b01, 16'h00AA); idle(0, 6);
        op(1, 0, 2'b10, 16'h5500); idle(0, 6);
        // R5: external edges drive the count
        ph = "R5";
        op(1, 2, 2'b11, 16'h8000);
        for (int i = 0; i < 40; i++) begin
            op(0, 0, 2'b00, 16'h0);
            if (i % 3 == 0) ext_clk_pin = ~ext_clk_pin;
        end
        // R4: slowest prescale
        ph = "R4";
        op(1, 2, 2'b11, 16'h0007); idle(0, 600);
        op(1, 2, 2'b01, 16'h000B); idle(0, 80);
        // random mix
        ph = "RND";
        for (int i = 0; i < 6000; i++) begin
            automatic int r = $urandom_range(0, 99);
            if ($urandom_range(0, 7) == 0) ext_clk_pin = ~ext_clk_pin;
            if (r < 4)
                op(1, 2, 2'($urandom_range(1, 3)),
                   {1'($urandom_range(0, 1)), 5'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0),
                    1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0), 3'($urandom_range(0, 2))});
            else if (r < 7)
                op(1, 1, 2'($urandom_range(0, 3)), 16'($urandom_range(0, 12)));
            else if (r < 9)
                op(1, 0, 2'($urandom_range(0, 3)), ($urandom_range(0, 1)) ? 16'hFFF8 : 16'h0);
            else
                op(0, 2'($urandom_range(0, 3)), 2'b00, 16'h0);
        end
        @(negedge clk); compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule